// File: doc/BRIEF.md
# Masked Write Buffer With Column-Block Transfer

This block is a small staging buffer between a fast word-wide port and a DRAM column-block write port. It holds eight 16-bit words. Each word is split into two byte lanes, and each byte carries a sticky mask bit. A set mask bit means "nothing new to send". Buffer writes store bytes and clear their mask bits. A transfer pushes the whole buffer to DRAM in one beat, with a per-byte write enable for each byte whose mask is clear and whose lane is enabled. It then sets every mask bit again, so stale bytes are never written twice.

A write and a transfer may be issued in the same cycle. In that case the new bytes are stored and are also merged into the outgoing transfer. A write with both lane enables low is a deselect and changes nothing. The transfer result is registered and appears on the DRAM side one clock after the command, marked by a one-cycle valid strobe.

Top module: `wbuf_xfer`

## Requirements
- R1: After reset every mask bit is set and `dram_valid`, `dram_col`, `dram_be` and `dram_data` are zero. A transfer issued before any write therefore drives `dram_be` = 0.
- R2: A buffer write (`wr_en`=1) stores `wr_data[7:0]` into the low byte of word `wr_addr` when `lane_en[0]`=1, and stores `wr_data[15:8]` into the high byte when `lane_en[1]`=1. A byte whose lane is disabled keeps its old value.
- R3: A buffer write clears the mask bit of each byte it stores: one bit for a single enabled lane, two bits for both lanes. Byte slot k = 2*word + lane, with lane 0 the low byte.
- R4: A transfer (`xfer_en`=1) raises `dram_valid` for exactly the following cycle. In that cycle `dram_col` holds the 5-bit `col_blk` from the command, and `dram_data` holds all eight words, word w at bits [16w+15:16w]. `dram_valid` is low in every cycle that does not follow a transfer.
- R5: During a transfer, `dram_be[k]` is 1 exactly when mask bit k is clear and `lane_en[k mod 2]` is 1 in the transfer command.
- R6: A transfer sets every mask bit. A following transfer drives `dram_be` = 0 unless later writes clear mask bits.
- R7: A write in the same cycle as a transfer is stored in the buffer. Its bytes appear in that transfer's `dram_data`, and their `dram_be` bits are set when their lanes are enabled. After the transfer all masks are set.
- R8: A write with `lane_en` = 2'b00 is a deselect: no data byte and no mask bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write command |
| xfer_en | input | 1 | Buffer-to-DRAM transfer command |
| wr_addr | input | 3 | Word index for the write |
| wr_data | input | 16 | Write data, high byte is lane 1 |
| lane_en | input | 2 | Byte-lane enables, bit 1 high byte, bit 0 low byte |
| col_blk | input | 5 | DRAM column block for the transfer |
| dram_valid | output | 1 | One-cycle transfer strobe |
| dram_col | output | 5 | Column block of the transfer |
| dram_data | output | 128 | All eight buffer words |
| dram_be | output | 16 | Per-byte write enables |

## Verification
The assertions assume that every command input is known, and is steady at each rising clock edge while reset is released. They also assume that `lane_en` qualifies both halves of a combined write-and-transfer. The bench drives all inputs on the falling edge from a single task, so those assumptions always hold. It sweeps every word address against every lane-enable pattern, including the double-disabled deselect. It also covers the combined cycle and back-to-back transfers, and checks them against a byte-level model of data and mask.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WB_ENTRIES = 8;
  localparam int WB_LANES   = 2;
  localparam int WB_LANE_W  = 8;
  localparam int WB_COL_W   = 5;

  // flat slot number of a byte: lanes of a word are adjacent
  function automatic int byte_slot(input int entry, input int lane, input int lanes);
    return entry * lanes + lane;
  endfunction

  // a byte is sent when it holds fresh data and its lane is open
  function automatic logic byte_grant(input logic mask_bit, input logic lane_on);
    return (!mask_bit) && lane_on;
  endfunction
endpackage

// File: rtl/wbuf_decode.sv
module wbuf_decode #(
  parameter int ENTRIES = wbuf_pkg::WB_ENTRIES,
  parameter int LANES   = wbuf_pkg::WB_LANES,
  localparam int AW     = $clog2(ENTRIES),
  localparam int NB     = ENTRIES * LANES
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] lane_en,
  output logic [NB-1:0]    hit,
  output logic             write_cmd,
  output logic             deselect
);
  assign write_cmd = wr_en && (|lane_en);
  assign deselect  = wr_en && !(|lane_en);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign hit[wbuf_pkg::byte_slot(e, l, LANES)] =
        write_cmd && (wr_addr == AW'(e)) && lane_en[l];
    end
  end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int ENTRIES = wbuf_pkg::WB_ENTRIES,
  parameter int LANES   = wbuf_pkg::WB_LANES,
  parameter int LANE_W  = wbuf_pkg::WB_LANE_W,
  localparam int NB     = ENTRIES * LANES,
  localparam int WW     = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     hit,
  input  logic              xfer_en,
  input  logic [WW-1:0]     wr_data,
  output logic [NB*LANE_W-1:0] merged_data,
  output logic [NB-1:0]     merged_mask,
  output logic [NB*LANE_W-1:0] state_data,
  output logic [NB-1:0]     state_mask
);
  logic [NB-1:0] mask_q;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam int LN = k % LANES;
    logic [LANE_W-1:0] data_q;
    logic [LANE_W-1:0] data_nx;

    assign data_nx = hit[k] ? wr_data[LN*LANE_W +: LANE_W] : data_q;
    assign merged_data[k*LANE_W +: LANE_W] = data_nx;
    assign state_data[k*LANE_W +: LANE_W]  = data_q;
    assign merged_mask[k] = mask_q[k] && !hit[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= data_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (xfer_en) mask_q <= '1;
    else              mask_q <= merged_mask;
  end

  assign state_mask = mask_q;

  // R3: written bytes lose their mask when no transfer re-arms them
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit) && !xfer_en) |=> ((mask_q & $past(hit)) == '0));

  // R6: a transfer leaves every mask bit set
  a_r6_rearm_all: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |=> (&mask_q));
endmodule

// File: rtl/wbuf_xfer_out.sv
module wbuf_xfer_out #(
  parameter int ENTRIES = wbuf_pkg::WB_ENTRIES,
  parameter int LANES   = wbuf_pkg::WB_LANES,
  parameter int LANE_W  = wbuf_pkg::WB_LANE_W,
  parameter int COL_W   = wbuf_pkg::WB_COL_W,
  localparam int NB     = ENTRIES * LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_en,
  input  logic [COL_W-1:0]     col_blk,
  input  logic [LANES-1:0]     lane_en,
  input  logic [NB*LANE_W-1:0] merged_data,
  input  logic [NB-1:0]        merged_mask,
  output logic                 dram_valid,
  output logic [COL_W-1:0]     dram_col,
  output logic [NB*LANE_W-1:0] dram_data,
  output logic [NB-1:0]        dram_be
);
  logic [NB-1:0] be_nx;

  for (genvar k = 0; k < NB; k++) begin : g_be
    assign be_nx[k] = wbuf_pkg::byte_grant(merged_mask[k], lane_en[k % LANES]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_valid <= 1'b0;
      dram_col   <= '0;
      dram_data  <= '0;
      dram_be    <= '0;
    end else begin
      dram_valid <= xfer_en;
      if (xfer_en) begin
        dram_col  <= col_blk;
        dram_data <= merged_data;
        dram_be   <= be_nx;
      end
    end
  end

  // R5: no enable may appear on a lane that the transfer closed
  a_r5_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |=> ((dram_be & ~{ENTRIES{$past(lane_en)}}) == '0));

  // R4: the strobe lasts one cycle per transfer command
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> !dram_valid);
endmodule

// File: rtl/wbuf_xfer.sv
module wbuf_xfer #(
  parameter int ENTRIES = wbuf_pkg::WB_ENTRIES,
  parameter int LANES   = wbuf_pkg::WB_LANES,
  parameter int LANE_W  = wbuf_pkg::WB_LANE_W,
  parameter int COL_W   = wbuf_pkg::WB_COL_W,
  localparam int AW     = $clog2(ENTRIES),
  localparam int NB     = ENTRIES * LANES,
  localparam int WW     = LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 xfer_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [WW-1:0]        wr_data,
  input  logic [LANES-1:0]     lane_en,
  input  logic [COL_W-1:0]     col_blk,
  output logic                 dram_valid,
  output logic [COL_W-1:0]     dram_col,
  output logic [NB*LANE_W-1:0] dram_data,
  output logic [NB-1:0]        dram_be
);
  logic [NB-1:0]        hit;
  logic                 write_cmd;
  logic                 deselect;
  logic [NB*LANE_W-1:0] merged_data;
  logic [NB-1:0]        merged_mask;
  logic [NB*LANE_W-1:0] state_data;
  logic [NB-1:0]        state_mask;

  wbuf_decode #(.ENTRIES(ENTRIES), .LANES(LANES)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .lane_en(lane_en),
    .hit(hit), .write_cmd(write_cmd), .deselect(deselect)
  );

  wbuf_store #(.ENTRIES(ENTRIES), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .hit(hit), .xfer_en(xfer_en), .wr_data(wr_data),
    .merged_data(merged_data), .merged_mask(merged_mask),
    .state_data(state_data), .state_mask(state_mask)
  );

  wbuf_xfer_out #(.ENTRIES(ENTRIES), .LANES(LANES), .LANE_W(LANE_W), .COL_W(COL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .col_blk(col_blk), .lane_en(lane_en),
    .merged_data(merged_data), .merged_mask(merged_mask),
    .dram_valid(dram_valid), .dram_col(dram_col), .dram_data(dram_data), .dram_be(dram_be)
  );

  // R8: a deselect write leaves buffer and masks untouched
  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (deselect && !xfer_en) |=> ($stable(state_data) && $stable(state_mask)));

  // R7: bytes written alongside a transfer are enabled in it
  a_r7_merge_be: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && write_cmd) |=> ((dram_be & $past(hit)) == $past(hit)));

  // R2: a stored byte equals the lane of the write data it came from
  a_r2_store_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (write_cmd && lane_en[0]) |=>
      (state_data[($past(wr_addr)*LANES)*LANE_W +: LANE_W] == $past(wr_data[LANE_W-1:0])));
endmodule

// File: tb/sim_wbuf_xfer.sv
module sim_wbuf_xfer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, xfer_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic [1:0]   lane_en = '0;
  logic [4:0]   col_blk = '0;
  logic         dram_valid;
  logic [4:0]   dram_col;
  logic [127:0] dram_data;
  logic [15:0]  dram_be;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] m_data [16];
  logic       m_mask [16];

  always #10 clk = ~clk;

  wbuf_xfer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .xfer_en(xfer_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lane_en(lane_en), .col_blk(col_blk),
    .dram_valid(dram_valid), .dram_col(dram_col), .dram_data(dram_data), .dram_be(dram_be)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit xf, input logic [2:0] a, input logic [15:0] d,
                      input logic [1:0] ln, input logic [4:0] c, input string req);
    logic [15:0]  exp_be;
    logic [127:0] exp_data;
    wr_en = wr; xfer_en = xf; wr_addr = a; wr_data = d; lane_en = ln; col_blk = c;
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      if (wr && ln != 2'b00 && (k / 2) == a && ln[k % 2]) begin
        m_data[k] = d[8 * (k % 2) +: 8];
        m_mask[k] = 1'b0;
      end
    end
    exp_be = '0; exp_data = '0;
    for (int k = 0; k < 16; k++) begin
      exp_be[k] = !m_mask[k] && ln[k % 2];
      exp_data[8 * k +: 8] = m_data[k];
    end
    if (xf) for (int k = 0; k < 16; k++) m_mask[k] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; xfer_en = 1'b0;
    chk(dram_valid == xf, {req, " R4 valid"}, 128'(dram_valid), 128'(xf));
    if (xf) begin
      chk(dram_col == c, {req, " R4 col"}, 128'(dram_col), 128'(c));
      chk(dram_be == exp_be, {req, " be"}, 128'(dram_be), 128'(exp_be));
      chk(dram_data == exp_data, {req, " data"}, dram_data, exp_data);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin m_data[k] = 8'h00; m_mask[k] = 1'b1; end
    repeat (2) @(negedge clk);
    chk(dram_valid == 1'b0 && dram_be == '0 && dram_col == '0, "R1 reset outputs",
        {dram_valid, dram_col, dram_be}, 128'h0);
    chk(dram_data == '0, "R1 reset data", dram_data, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // transfer before any write: all masks set
    step(0, 1, 3'd0, 16'h0, 2'b11, 5'd7, "R1 early xfer");
    // sweep every word against every lane pattern, then transfer
    for (int a = 0; a < 8; a++) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [15:0] d;
        d = 16'hA55A ^ 16'(a * 16'h1357) ^ 16'(ln * 16'h0F0F);
        step(1, 0, 3'(a), d, 2'(ln), 5'd0, ln == 0 ? "R8 deselect" : "R2 write");
        step(0, 1, 3'd0, 16'h0, 2'b11, 5'(a * 4 + ln), ln == 0 ? "R8 after deselect" : "R3 R5 xfer");
      end
    end
    // fill, then transfer on the low lane only, then again
    for (int a = 0; a < 8; a++) step(1, 0, 3'(a), 16'(16'h1200 + a * 16'h0101), 2'b11, 5'd0, "R2 fill");
    step(0, 1, 3'd0, 16'h0, 2'b01, 5'd31, "R5 low lane");
    step(0, 1, 3'd0, 16'h0, 2'b11, 5'd30, "R6 rearmed");
    // high-lane-only transfer after partial writes
    step(1, 0, 3'd2, 16'hBEEF, 2'b11, 5'd0, "R3 two bits");
    step(1, 0, 3'd5, 16'hC0DE, 2'b10, 5'd0, "R3 one bit");
    step(0, 1, 3'd0, 16'h0, 2'b10, 5'd9, "R5 high lane");
    // same-cycle write and transfer
    step(1, 0, 3'd1, 16'h1111, 2'b01, 5'd0, "R2 pre");
    step(1, 1, 3'd6, 16'h6789, 2'b11, 5'd12, "R7 merged");
    step(0, 1, 3'd0, 16'h0, 2'b11, 5'd13, "R7 R6 after merge");
    step(1, 1, 3'd4, 16'h4444, 2'b10, 5'd14, "R7 merged high");
    step(1, 1, 3'd3, 16'hDEAD, 2'b00, 5'd15, "R8 deselect in xfer");
    step(0, 0, 3'd0, 16'h0, 2'b11, 5'd0, "R4 idle");
    step(0, 1, 3'd0, 16'h0, 2'b11, 5'd16, "R6 final");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule